// File: doc/BRIEF.md
# Dual-Rate Counter Glue Logic

This block holds three free-running incrementers of unequal width, each of which can be parked, advanced on every cycle of the system clock, or advanced once per heartbeat tick. A small control machine holds one mode field per incrementer. Outside logic rewrites one field, or all three together, through a single command strobe. The current contents of all three fields are reported on a state output, next to the three counter values.

The heartbeat is not a second clock. An internal divider emits a one-cycle enable every `TICK_DIV` system cycles, so everything runs on one clock. The default ratio of 1000 turns a 32 MHz system clock into a heartbeat near 32 kHz. Typical use is glue between a fast bus domain and slow housekeeping events, where a counter tracks elapsed time at coarse or fine resolution, or is frozen while its client sleeps.

Top module: `dual_rate_glue`

## Requirements
- R1: Counters 0, 1 and 2 are `W0`, `W1` and `W2` bits wide (defaults 4, 8, 12). Each wraps from all-ones to zero on its next increment.
- R2: `state_o` carries the mode of counter 0 in bits [1:0], of counter 1 in bits [3:2] and of counter 2 in bits [5:4]. The mode codes are 00 parked, 01 heartbeat rate and 10 system rate.
- R3: A counter whose mode field is 10 increases by one at every clock edge.
- R4: A counter whose mode field is 01 increases by one only at edges where the heartbeat enable is high. That enable is high for one cycle out of every `TICK_DIV`. After reset it is first high in the `TICK_DIV`-th cycle, counting the first cycle after reset as cycle 1.
- R5: A counter whose mode field is 00 or 11 keeps its value, and counting later resumes from that held value. Code 11 is stored and reported as 11.
- R6: When `cmd_valid` is high at an edge, the field picked by `cmd_sel` (0, 1 or 2) takes `cmd_mode` at that edge. The counter follows its new mode from the next edge on, so the command edge itself still uses the old mode.
- R7: A command with `cmd_sel` equal to 3 writes `cmd_mode` into all three fields at once.
- R8: While `cmd_valid` is low, `state_o` does not change, whatever `cmd_sel` and `cmd_mode` hold.
- R9: A synchronous high `rst` clears all counters, sets all mode fields to 00 and restarts the heartbeat divider phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_sel | input | 2 | Target field: 0..2 one counter, 3 all |
| cmd_mode | input | 2 | Mode code to write |
| cnt0_o | output | W0 | Counter 0 value |
| cnt1_o | output | W1 | Counter 1 value |
| cnt2_o | output | W2 | Counter 2 value |
| state_o | output | 6 | Packed mode fields |

## Verification
The bench keeps the default widths and shrinks `TICK_DIV` to 5. With that ratio, heartbeat-rate counting wraps the 4-bit counter within about 80 cycles, and the tick phase is crossed by many mode changes during random command traffic. Because the 12-bit counter keeps its default width, its wrap is still reachable in about 4100 cycles at the system rate. A mid-run reset checks that the divider phase restarts along with the counters.

// File: rtl/glue_pkg.sv
package glue_pkg;
    localparam int NUM_CNT = 3;

    typedef logic [1:0] mode_t;

    localparam mode_t MODE_PARK = 2'b00;
    localparam mode_t MODE_SLOW = 2'b01;
    localparam mode_t MODE_FAST = 2'b10;

    localparam logic [1:0] SEL_ALL = 2'b11;

    typedef mode_t [NUM_CNT-1:0] mode_vec_t;
endpackage

// File: rtl/hb_tick_gen.sv
module hb_tick_gen #(
    parameter int unsigned TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    typedef struct packed {
        logic [DW-1:0] phase;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.phase == LAST);

    // R4: the phase never leaves its range
    a_r4_phase_range: assert property (@(posedge clk) disable iff (rst)
        st_q.phase <= LAST);

    generate
        if (TICK_DIV > 1) begin : g_multi
            // R4: the enable lasts exactly one cycle
            a_r4_tick_single: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
            // R9: the first cycle after reset carries no tick
            a_r9_phase_restart: assert property (@(posedge clk)
                rst |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
    import glue_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_sel,
    input  mode_t      cmd_mode,
    output mode_vec_t  modes_o
);
    typedef struct packed {
        mode_vec_t modes;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (cmd_valid && (cmd_sel == SEL_ALL || cmd_sel == 2'(i))) begin
                st_d.modes[i] = cmd_mode;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign modes_o = st_q.modes;

    // R8: no strobe, no change
    a_r8_hold_state: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(modes_o));
    // R7: broadcast writes every field
    a_r7_broadcast: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_sel == SEL_ALL) |=>
            (modes_o[0] == $past(cmd_mode) && modes_o[1] == $past(cmd_mode)
             && modes_o[2] == $past(cmd_mode)));
    // R6: a single-field write touches only its field
    a_r6_single_field: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_sel == 2'd1) |=>
            (modes_o[1] == $past(cmd_mode) && $stable(modes_o[0])
             && $stable(modes_o[2])));
    // R9: reset parks every counter
    a_r9_reset_park: assert property (@(posedge clk)
        rst |=> modes_o == '0);
endmodule

// File: rtl/rate_counter.sv
module rate_counter
    import glue_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_t        mode,
    input  logic         tick,
    output logic [W-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic step;

    always_comb begin
        case (mode)
            MODE_FAST: step = 1'b1;
            MODE_SLOW: step = tick;
            default:   step = 1'b0;
        endcase
        st_d = st_q;
        if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R3: system-rate step
    a_r3_fast_step: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FAST) |=> cnt_o == $past(cnt_o) + W'(1));
    // R4: heartbeat-rate step only on tick
    a_r4_slow_tick: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLOW && tick) |=> cnt_o == $past(cnt_o) + W'(1));
    a_r4_slow_wait: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLOW && !tick) |=> $stable(cnt_o));
    // R5: parked (00 or 11) holds
    a_r5_park_hold: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_FAST && mode != MODE_SLOW) |=> $stable(cnt_o));
    // R1: all-ones wraps to zero
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FAST && cnt_o == '1) |=> cnt_o == '0);
    // R9: reset clears
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> cnt_o == '0);
endmodule

// File: rtl/dual_rate_glue.sv
module dual_rate_glue
    import glue_pkg::*;
#(
    parameter int          W0       = 4,
    parameter int          W1       = 8,
    parameter int          W2       = 12,
    parameter int unsigned TICK_DIV = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_sel,
    input  logic [1:0]    cmd_mode,
    output logic [W0-1:0] cnt0_o,
    output logic [W1-1:0] cnt1_o,
    output logic [W2-1:0] cnt2_o,
    output logic [5:0]    state_o
);
    logic      hb_tick;
    mode_vec_t modes;

    hb_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (hb_tick)
    );

    mode_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_sel   (cmd_sel),
        .cmd_mode  (cmd_mode),
        .modes_o   (modes)
    );

    rate_counter #(.W(W0)) u_cnt0 (
        .clk   (clk),
        .rst   (rst),
        .mode  (modes[0]),
        .tick  (hb_tick),
        .cnt_o (cnt0_o)
    );

    rate_counter #(.W(W1)) u_cnt1 (
        .clk   (clk),
        .rst   (rst),
        .mode  (modes[1]),
        .tick  (hb_tick),
        .cnt_o (cnt1_o)
    );

    rate_counter #(.W(W2)) u_cnt2 (
        .clk   (clk),
        .rst   (rst),
        .mode  (modes[2]),
        .tick  (hb_tick),
        .cnt_o (cnt2_o)
    );

    assign state_o = modes;

    // R2: reported fields match the packed layout of counter 0
    a_r2_field0: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_sel == 2'd0) |=> state_o[1:0] == $past(cmd_mode));
endmodule

// File: tb/dual_rate_glue_tb.sv
`timescale 1ns/1ps
module dual_rate_glue_tb;
    localparam int TDIV = 5;
    localparam int W0 = 4;
    localparam int W1 = 8;
    localparam int W2 = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_sel = '0;
    logic [1:0]    cmd_mode = '0;
    logic [W0-1:0] cnt0_o;
    logic [W1-1:0] cnt1_o;
    logic [W2-1:0] cnt2_o;
    logic [5:0]    state_o;

    dual_rate_glue #(.W0(W0), .W1(W1), .W2(W2), .TICK_DIV(TDIV)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_mode(cmd_mode), .cnt0_o(cnt0_o), .cnt1_o(cnt1_o),
        .cnt2_o(cnt2_o), .state_o(state_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int m_cnt [3];
    int m_mode [3];
    int m_dc;

    function automatic int wmask(int i);
        int w;
        w = (i == 0) ? W0 : (i == 1) ? W1 : W2;
        return (1 << w) - 1;
    endfunction

    function automatic int dut_cnt(int i);
        if (i == 0) return int'(cnt0_o);
        if (i == 1) return int'(cnt1_o);
        return int'(cnt2_o);
    endfunction

    function automatic int exp_state();
        return (m_mode[2] << 4) | (m_mode[1] << 2) | m_mode[0];
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_all();
        for (int i = 0; i < 3; i++) begin
            string tag;
            tag = (m_mode[i] == 2) ? "R3" : (m_mode[i] == 1) ? "R4" : "R5";
            chk(tag, $sformatf("counter%0d", i), dut_cnt(i), m_cnt[i]);
        end
        chk("R2", "state", int'(state_o), exp_state());
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            m_cnt[i] = 0;
            m_mode[i] = 0;
        end
        m_dc = 0;
    endtask

    task automatic model_edge(bit v, int s, int m);
        bit tk;
        tk = (m_dc == TDIV - 1);
        for (int i = 0; i < 3; i++) begin
            if (m_mode[i] == 2 || (m_mode[i] == 1 && tk))
                m_cnt[i] = (m_cnt[i] + 1) & wmask(i);
        end
        if (v) begin
            for (int i = 0; i < 3; i++)
                if (s == 3 || s == i) m_mode[i] = m;
        end
        m_dc = tk ? 0 : m_dc + 1;
    endtask

    task automatic step(bit v, int s, int m);
        cmd_valid = v;
        cmd_sel   = 2'(s);
        cmd_mode  = 2'(m);
        @(posedge clk);
        model_edge(v, s, m);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        chk("R9", "cnt0 after reset", int'(cnt0_o), 0);
        chk("R9", "cnt1 after reset", int'(cnt1_o), 0);
        chk("R9", "cnt2 after reset", int'(cnt2_o), 0);
        chk("R9", "state after reset", int'(state_o), 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run hung actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int held;
        void'($urandom(32'd4242));
        do_reset();

        // R6: command edge keeps the old mode, next edge counts
        step(1, 0, 2);
        chk("R6", "cnt0 on command edge", int'(cnt0_o), 0);
        chk("R6", "field0 written", int'(state_o[1:0]), 2);
        step(0, 0, 0);
        chk("R6", "cnt0 one edge later", int'(cnt0_o), 1);

        // R1: 4-bit wrap after 16 increments
        repeat (15) step(0, 0, 0);
        chk("R1", "cnt0 wrapped", int'(cnt0_o), 0);

        // R5: park, hold, then code 11 also holds
        repeat (3) step(0, 0, 0);
        step(1, 0, 0);
        held = int'(cnt0_o);
        repeat (10) step(0, 0, 0);
        chk("R5", "cnt0 parked", int'(cnt0_o), held);
        step(1, 0, 3);
        repeat (10) step(0, 0, 0);
        chk("R5", "cnt0 under code 11", int'(cnt0_o), held);
        chk("R5", "code 11 reported", int'(state_o[1:0]), 3);
        step(1, 0, 2);
        step(0, 0, 0);
        chk("R5", "cnt0 resumes from held", int'(cnt0_o), (held + 1) & 15);

        // R8: strobe low leaves state alone
        held = int'(state_o);
        step(0, 1, 1);
        step(0, 3, 0);
        chk("R8", "state unchanged", int'(state_o), held);

        // R7: broadcast fast, run past the 12-bit wrap
        step(1, 3, 2);
        chk("R7", "broadcast fields", int'(state_o), 6'b101010);
        repeat (4100) step(0, 0, 0);
        chk("R1", "cnt2 after wrap", int'(cnt2_o), m_cnt[2]);

        // R4: broadcast heartbeat rate
        step(1, 3, 1);
        held = int'(cnt1_o);
        repeat (10 * TDIV) step(0, 0, 0);
        chk("R4", "cnt1 ten ticks", int'(cnt1_o), (held + 10) & 255);

        // random command traffic
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 4) == 0, int'($urandom % 4), int'($urandom % 4));
        end

        // R9: mid-run reset, then R4 first tick position
        do_reset();
        step(1, 1, 1);
        repeat (TDIV - 2) step(0, 0, 0);
        chk("R4", "no tick before cycle TICK_DIV", int'(cnt1_o), 0);
        step(0, 0, 0);
        chk("R4", "first tick counted", int'(cnt1_o), 1);

        for (int n = 0; n < 1000; n++) begin
            step(($urandom % 3) == 0, int'($urandom % 4), int'($urandom % 4));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule